// File: doc/BRIEF.md
# Banked BCD Calendar Clock Core

This block is a real-time calendar that keeps the time as fifteen decimal digits, one per 4-bit register. Software reaches it through a small parallel register window of sixteen addresses. A single-cycle one-second strobe drives the count. Each accepted strobe opens a short busy interval, and the seconds advance inside it. Carries then ripple into minutes, hours, weekday, day, month and a four-digit year. The day carry follows month lengths and the Gregorian leap-year rule.

The top address of the window holds a control nibble in every bank. It reports the busy interval, holds a freeze bit and selects one of four banks. Software sets the freeze bit, writes the digits and clears the bit to restart the count. Before reading, software polls the busy bit until it reads zero. Only bank 0 holds storage in this core. The other banks are decoded, read as zero and ignore writes. The bank number also drives an output so that neighbouring alarm or timer logic can follow it.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the digits read 2000-01-01 00:00:00 with weekday 0, and the control nibble reads 0. That means not frozen, bank 0 and not busy.
- R2: In bank 0, addresses 0 to 14 hold, in this order: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, weekday, day units, day tens, month units, month tens, year units, year tens, year hundreds and year thousands. A write stores the nibble and a read returns it on the 4-bit read bus.
- R3: Bit 3 is dropped on writes to address 1, 3, 5, 6 or 8, so it always reads 0. All other digit addresses keep all four bits.
- R4: Address 15 is the control nibble and is decoded in every bank. Bit 0 reads the busy state and ignores writes. Bit 1 is the freeze bit. Bits 3:2 are the bank number, and the bank_sel output always equals them.
- R5: When the bank is 1, 2 or 3, addresses 0 to 14 read 0 and writes to them leave the digits unchanged.
- R6: While the freeze bit is 1, strobes are ignored: busy stays 0 and the digits change only through bus writes. After the bit is cleared, the next strobe advances the time again.
- R7: A strobe seen while not frozen and not busy raises busy from the next cycle on, for BUSY_LEN cycles. The one-second advance happens within that interval. Outside it, the digits change only through bus writes.
- R8: Seconds roll from 59 to 00 with a carry into minutes. Minutes roll from 59 to 00 with a carry into hours. Hours roll from 23 to 00 with a carry into the day.
- R9: On a day carry, the last day of the month returns to day 1 and carries into the month. Months 4, 6, 9 and 11 have 30 days and the others 31. February has 29 days when the year is divisible by 4, except years divisible by 100 but not by 400, which give 28.
- R10: The weekday counts 0 to 6 and wraps from 6 to 0 on each day carry.
- R11: Months are 1 to 12. A carry out of month 12 gives month 1 and adds one to the four-digit decimal year, and 9999 wraps to 0000.
- R12: A digit write while running and not busy is stored at once. The next strobe advances from the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_we | input | 1 | Write strobe for the register window |
| bus_addr | input | 4 | Register address (read and write) |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Read data nibble for bus_addr (combinational) |
| bank_sel | output | 2 | Current bank number, for neighbouring logic |

## Verification
The calendar is driven with three kinds of input pattern. A run of two hundred consecutive strobes starting just before midnight shows whether the ripple from seconds through minutes and hours into the day is correct. A sweep over every month end, in seven chosen years, tells the 28, 29, 30 and 31 day limits apart. The years cover leap, non-leap, century and 400-year cases, plus 9999, so both the leap rule and the year digit carry are exposed. Separate directed patterns cover masked bits, banks other than 0, the freeze bit, the length of the busy interval and a write while running, so each of these can be told apart from a plain count.

// File: rtl/bcdclk_pkg.sv
package bcdclk_pkg;
  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 15;
  localparam int ADDR_W     = 4;
  localparam int BANK_W     = 2;
  localparam int VAL_W      = 8;
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_DIGITS);

  // digit slots; the order is the register address
  localparam int SEC_U = 0,  SEC_T = 1,  MIN_U = 2,  MIN_T = 3;
  localparam int HR_U  = 4,  HR_T  = 5,  WDAY  = 6,  DAY_U = 7;
  localparam int DAY_T = 8,  MON_U = 9,  MON_T = 10, YR_0  = 11;
  localparam int YR_1  = 12, YR_2  = 13, YR_3  = 14;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits_t;
  typedef logic [VAL_W-1:0] val_t;

  function automatic val_t bcd_val(digit_t tens, digit_t units);
    return {{(VAL_W-DIGIT_W){1'b0}}, tens} * val_t'(10) + {{(VAL_W-DIGIT_W){1'b0}}, units};
  endfunction

  function automatic digit_t tens_of(val_t v);
    return digit_t'(v / val_t'(10));
  endfunction

  function automatic digit_t units_of(val_t v);
    return digit_t'(v % val_t'(10));
  endfunction

  // slots whose bit 3 is not part of the value
  function automatic digit_t store_mask(int idx);
    return (idx == SEC_T || idx == MIN_T || idx == HR_T || idx == WDAY || idx == DAY_T)
           ? digit_t'(7) : digit_t'(15);
  endfunction

  // leap test on decimal digits: century years use the upper pair
  function automatic logic leap_year(digits_t t);
    val_t lo, hi;
    lo = bcd_val(t[YR_1], t[YR_0]);
    hi = bcd_val(t[YR_3], t[YR_2]);
    return (lo == val_t'(0)) ? (hi[1:0] == 2'b00) : (lo[1:0] == 2'b00);
  endfunction

  function automatic val_t month_len(val_t mon, logic leap);
    case (mon)
      val_t'(2):                                 return leap ? val_t'(29) : val_t'(28);
      val_t'(4), val_t'(6), val_t'(9), val_t'(11): return val_t'(30);
      default:                                   return val_t'(31);
    endcase
  endfunction

  function automatic digits_t reset_digits();
    digits_t r;
    r        = '0;
    r[DAY_U] = digit_t'(1);
    r[MON_U] = digit_t'(1);
    r[YR_3]  = digit_t'(2);
    return r;
  endfunction

  // one second later, with the full carry chain
  function automatic digits_t next_time(digits_t t);
    digits_t n;
    val_t    v;
    val_t    lim;
    logic    cy;
    n  = t;
    v  = bcd_val(t[SEC_T], t[SEC_U]);
    cy = (v >= val_t'(59));
    v  = cy ? val_t'(0) : v + val_t'(1);
    n[SEC_T] = tens_of(v);
    n[SEC_U] = units_of(v);
    if (cy) begin
      v  = bcd_val(t[MIN_T], t[MIN_U]);
      cy = (v >= val_t'(59));
      v  = cy ? val_t'(0) : v + val_t'(1);
      n[MIN_T] = tens_of(v);
      n[MIN_U] = units_of(v);
    end
    if (cy) begin
      v  = bcd_val(t[HR_T], t[HR_U]);
      cy = (v >= val_t'(23));
      v  = cy ? val_t'(0) : v + val_t'(1);
      n[HR_T] = tens_of(v);
      n[HR_U] = units_of(v);
    end
    if (cy) begin
      n[WDAY] = (t[WDAY] >= digit_t'(6)) ? digit_t'(0) : t[WDAY] + digit_t'(1);
      lim = month_len(bcd_val(t[MON_T], t[MON_U]), leap_year(t));
      v   = bcd_val(t[DAY_T], t[DAY_U]);
      cy  = (v >= lim);
      v   = cy ? val_t'(1) : v + val_t'(1);
      n[DAY_T] = tens_of(v);
      n[DAY_U] = units_of(v);
    end
    if (cy) begin
      v  = bcd_val(t[MON_T], t[MON_U]);
      cy = (v >= val_t'(12));
      v  = cy ? val_t'(1) : v + val_t'(1);
      n[MON_T] = tens_of(v);
      n[MON_U] = units_of(v);
    end
    for (int i = YR_0; i <= YR_3; i++) begin
      if (cy) begin
        if (n[i] >= digit_t'(9)) n[i] = '0;
        else begin
          n[i] = n[i] + digit_t'(1);
          cy   = 1'b0;
        end
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/bcdclk_tick_seq.sv
module bcdclk_tick_seq #(
  parameter int BUSY_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic stop,
  output logic busy,
  output logic upd
);
  localparam int CW = $clog2(BUSY_LEN + 1);
  localparam logic [CW-1:0] LEN_V  = CW'(BUSY_LEN);
  localparam logic [CW-1:0] UPD_AT = CW'((BUSY_LEN + 1) / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
    else if (tick && !stop)   cnt_q <= LEN_V;
  end

  assign busy = (cnt_q != '0);
  assign upd  = (cnt_q == UPD_AT) && !stop;

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !busy) |=> busy);

  // R6
  stop_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stop && !busy) |=> !busy);
endmodule

// File: rtl/bcdclk_calendar.sv
module bcdclk_calendar
  import bcdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  digit_t            wr_data,
  output digits_t           digits
);
  digits_t tm_q;
  digits_t tm_d;

  // a bus write wins over the update for the digit it hits
  always_comb begin
    tm_d = upd ? next_time(tm_q) : tm_q;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (wr_en && wr_addr == ADDR_W'(i)) tm_d[i] = wr_data & store_mask(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tm_q <= reset_digits();
    else        tm_q <= tm_d;
  end

  assign digits = tm_q;

  // R8
  hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_en) |=> (bcd_val(tm_q[HR_T], tm_q[HR_U]) <= val_t'(23)));

  // R8
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_en && tm_q[SEC_U] < digit_t'(9)) |=> (tm_q[SEC_U] == $past(tm_q[SEC_U]) + digit_t'(1)));
endmodule

// File: rtl/bcdclk_regif.sv
module bcdclk_regif
  import bcdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  digit_t            bus_wdata,
  input  logic              busy,
  input  digits_t           digits,
  output digit_t            bus_rdata,
  output logic              stop,
  output logic [BANK_W-1:0] bank,
  output logic              cal_wr
);
  logic              stop_q;
  logic [BANK_W-1:0] bank_q;
  logic              ctl_hit;

  assign ctl_hit = (bus_addr == CTL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      bank_q <= '0;
    end else if (bus_we && ctl_hit) begin
      stop_q <= bus_wdata[1];
      bank_q <= bus_wdata[3:2];
    end
  end

  assign cal_wr = bus_we && !ctl_hit && (bank_q == '0);
  assign stop   = stop_q;
  assign bank   = bank_q;

  always_comb begin
    bus_rdata = '0;
    if (ctl_hit) bus_rdata = {bank_q, stop_q, busy};
    else if (bank_q == '0) begin
      for (int i = 0; i < NUM_DIGITS; i++) begin
        if (bus_addr == ADDR_W'(i)) bus_rdata = digits[i];
      end
    end
  end

  // R4
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ctl_hit) |=> (bank_q == $past(bus_wdata[3:2]) && stop_q == $past(bus_wdata[1])));
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import bcdclk_pkg::*;
#(
  parameter int BUSY_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DIGIT_W-1:0] bus_wdata,
  output logic [DIGIT_W-1:0] bus_rdata,
  output logic [BANK_W-1:0] bank_sel
);
  logic    busy;
  logic    upd;
  logic    stop;
  logic    cal_wr;
  digits_t digits;

  bcdclk_tick_seq #(.BUSY_LEN(BUSY_LEN)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_1hz),
    .stop (stop),
    .busy (busy),
    .upd  (upd)
  );

  bcdclk_calendar u_cal (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (upd),
    .wr_en  (cal_wr),
    .wr_addr(bus_addr),
    .wr_data(bus_wdata),
    .digits (digits)
  );

  bcdclk_regif u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .busy     (busy),
    .digits   (digits),
    .bus_rdata(bus_rdata),
    .stop     (stop),
    .bank     (bank_sel),
    .cal_wr   (cal_wr)
  );

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cal_wr) |=> $stable(digits));

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !cal_wr) |=> $stable(digits));

  // R5
  bank_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bank_sel != '0 && bus_addr != CTL_ADDR && !busy) |=> $stable(digits));
endmodule

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;
  localparam int BUSY_LEN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [3:0] wdata = 4'd0;
  logic [3:0] rdata;
  logic [1:0] bank_sel;

  int checks = 0;
  int errors = 0;
  int last_busy = 0;
  int e_y, e_mo, e_d, e_w, e_h, e_mi, e_s;

  always #5 clk = ~clk;

  bcd_calendar_clock #(.BUSY_LEN(BUSY_LEN)) u_bcd_calendar_clock (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bank_sel(bank_sel)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit leap(input int y);
    return (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
  endfunction

  function automatic int days_in(input int y, input int m);
    if (m == 2) return leap(y) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int exp_digit(input int i);
    case (i)
      0: return e_s % 10;          1: return e_s / 10;
      2: return e_mi % 10;         3: return e_mi / 10;
      4: return e_h % 10;          5: return e_h / 10;
      6: return e_w;               7: return e_d % 10;
      8: return e_d / 10;          9: return e_mo % 10;
      10: return e_mo / 10;        11: return e_y % 10;
      12: return (e_y / 10) % 10;  13: return (e_y / 100) % 10;
      default: return e_y / 1000;
    endcase
  endfunction

  task automatic model_tick();
    e_s++;
    if (e_s == 60) begin
      e_s = 0; e_mi++;
      if (e_mi == 60) begin
        e_mi = 0; e_h++;
        if (e_h == 24) begin
          e_h = 0; e_w = (e_w + 1) % 7; e_d++;
          if (e_d > days_in(e_y, e_mo)) begin
            e_d = 1; e_mo++;
            if (e_mo > 12) begin
              e_mo = 1; e_y = (e_y + 1) % 10000;
            end
          end
        end
      end
    end
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = 4'(v);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    we = 1'b0; addr = 4'(a);
    #1 v = int'(rdata);
  endtask

  // pulse one strobe, then count the cycles busy reads high
  task automatic do_tick();
    @(negedge clk);
    we = 1'b0; addr = 4'd15; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    last_busy = 0;
    #1;
    for (int k = 0; k < 40; k++) begin
      if (rdata[0]) last_busy++;
      else break;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int w,
                          input int h, input int mi, input int s);
    e_y = y; e_mo = mo; e_d = d; e_w = w; e_h = h; e_mi = mi; e_s = s;
    wr(15, 2);
    for (int i = 0; i < 15; i++) wr(i, exp_digit(i));
    wr(15, 0);
  endtask

  task automatic check_time(input string req, input int upto);
    int v;
    for (int i = 0; i < upto; i++) begin
      rd(i, v);
      check(req, $sformatf("digit %0d", i), v, exp_digit(i));
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog (R1..R12 run) actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int years[7] = '{1999, 2024, 1900, 2000, 2100, 2099, 9999};
    int masked[5] = '{1, 3, 5, 6, 8};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    e_y = 2000; e_mo = 1; e_d = 1; e_w = 0; e_h = 0; e_mi = 0; e_s = 0;
    check_time("R1", 15);
    rd(15, v);
    check("R1", "control", v, 0);
    check("R1", "bank_sel", int'(bank_sel), 0);

    // R2 map order and storage
    set_time(1987, 11, 23, 4, 15, 42, 36);
    check_time("R2", 15);

    // R3 bit 3 masking
    wr(15, 2);
    foreach (masked[j]) begin
      wr(masked[j], 15);
      rd(masked[j], v);
      check("R3", $sformatf("masked addr %0d", masked[j]), v, 7);
    end
    wr(0, 15);  rd(0, v);  check("R3", "full addr 0", v, 15);
    wr(9, 15);  rd(9, v);  check("R3", "full addr 9", v, 15);
    wr(12, 15); rd(12, v); check("R3", "full addr 12", v, 15);
    set_time(1987, 11, 23, 4, 15, 42, 36);

    // R4 control nibble
    wr(15, 15);
    rd(15, v);
    check("R4", "control stop+bank3", v, 14);
    check("R4", "bank_sel 3", int'(bank_sel), 3);
    wr(15, 5);
    rd(15, v);
    check("R4", "control bank1 busy ignored", v, 4);
    check("R4", "bank_sel 1", int'(bank_sel), 1);

    // R5 other banks
    wr(15, 6);
    wr(0, 9);
    rd(0, v);  check("R5", "bank1 addr 0", v, 0);
    rd(7, v);  check("R5", "bank1 addr 7", v, 0);
    wr(15, 10);
    wr(3, 1);
    rd(3, v);  check("R5", "bank2 addr 3", v, 0);
    wr(15, 14);
    rd(14, v); check("R5", "bank3 addr 14", v, 0);
    wr(15, 2);
    check_time("R5", 15);

    // R6 freeze: strobe ignored
    do_tick();
    check("R6", "busy cycles while frozen", last_busy, 0);
    check_time("R6", 15);
    wr(15, 0);
    do_tick();
    model_tick();
    // R7 busy interval length
    check("R7", "busy cycles", last_busy, BUSY_LEN);
    check_time("R6", 15);

    // R12 write while running
    wr(0, 5);
    e_s = e_s - (e_s % 10) + 5;
    rd(0, v);
    check("R12", "written seconds units", v, 5);
    do_tick();
    model_tick();
    check_time("R12", 15);

    // R8 long run across midnight
    set_time(2023, 6, 10, 2, 23, 57, 50);
    for (int n = 0; n < 200; n++) begin
      do_tick();
      model_tick();
      check_time("R8", 6);
    end
    check_time("R8", 15);

    // R9 R10 R11 month-end sweep
    foreach (years[yi]) begin
      for (int m = 1; m <= 12; m++) begin
        set_time(years[yi], m, days_in(years[yi], m), m % 7, 23, 59, 59);
        do_tick();
        model_tick();
        if (m == 12)     check_time("R11", 15);
        else if (m == 6) check_time("R10", 15);
        else             check_time("R9", 15);
      end
      set_time(years[yi], 2, 28, 6, 23, 59, 59);
      do_tick();
      model_tick();
      check_time("R9", 15);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule